// File: doc/BRIEF.md
# Private Peripheral Window Decoder

This block sits in front of a 4 KB private peripheral window that up to four processors share. Each access carries a byte address, a write flag, write data and the index of the requesting processor. The block decodes the low 12 address bits. It sends the access to one of three places: its own small snoop-control register set, one per-processor interrupt-controller CPU interface, or one per-processor timer/watchdog pair. The interrupt and timer logic lives outside the block. The block reaches it through a select line, a processor index, a timer index and a forwarded register offset, and it returns that logic's read data without a register stage.

Every interrupt interface and every timer pair can be reached in two ways. The first is an alias page, which is banked by the index of the requesting processor. The second is a set of explicit per-processor pages. An index that names a processor that is not fitted is masked without an error: the access selects nothing, reads return zero and writes are lost. Any offset outside the decoded map raises a registered error pulse.

The access interface follows the stream rules with a valid qualifier and no back-pressure. The block is always ready, so every cycle with `req_valid` high is one complete access that is decoded in that same cycle. A source may hold `req_valid` high for back-to-back accesses.

Top module: `priv_window_decoder`

## Requirements
- R1: After reset `scu_enable` and `err_flag` are 0. With `req_valid` low, all three selects, `tgt_write` and `rd_data` are 0.
- R2: A write to offset 0x000 stores `req_wdata[0]` into `scu_enable` at the next clock edge and ignores every other data bit. A read of 0x000 returns `scu_enable` in bit 0, with zeros above it.
- R3: A read of offset 0x004 returns `((1 << N_CPU) - 1) << 4 | (N_CPU - 1)`. With N_CPU = 3 this is 0x72. Reads of 0x008 and 0x00C return 0. A write to 0x00C is legal and changes nothing.
- R4: Offsets 0x100-0x1FF assert `sel_gic` with `gic_cpu = req_cpu` and `gic_offset = addr[7:0]`, and `rd_data` equals `gic_rdata`.
- R5: Offsets 0x200-0x5FF assert `sel_gic` with `gic_cpu = addr[11:8] - 2` and `gic_offset = addr[7:0]`.
- R6: Offsets 0x600-0x6FF assert `sel_tmr`. In that case `tmr_index = {req_cpu, addr[5]}`, where bit 0 is 0 for the timer and 1 for the watchdog. `tmr_offset` is `addr[3:0]` and `rd_data` equals `tmr_rdata`.
- R7: Offsets 0x700-0xAFF assert `sel_tmr` with `tmr_index = {addr[11:8] - 7, addr[5]}` and `tmr_offset = addr[3:0]`.
- R8: If the processor index, whether explicit or taken from the alias, is not less than N_CPU, the access selects nothing, `rd_data` is 0, `tgt_write` is 0 and `err_flag` stays 0.
- R9: The following are illegal accesses: offsets at or above 0xB00, SCU offsets other than 0x000/0x004/0x008/0x00C, and writes to 0x004 or 0x008. An illegal access selects nothing, returns 0 and raises `err_flag` in the following cycle for exactly that one cycle.
- R10: At most one of `sel_scu`, `sel_gic` and `sel_tmr` is high in any cycle. `tgt_write` is high only with `sel_gic` or `sel_tmr` on a write.
- R11: Address bits at and above bit 12 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access present this cycle (always accepted) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; low 12 bits decoded |
| req_wdata | input | DATA_W | Write data |
| req_cpu | input | 2 | Index of requesting processor |
| gic_rdata | input | DATA_W | Read data from selected interrupt interface |
| tmr_rdata | input | DATA_W | Read data from selected timer/watchdog |
| rd_data | output | DATA_W | Combinational read data |
| sel_scu | output | 1 | Legal snoop-control register access |
| sel_gic | output | 1 | Interrupt interface selected |
| sel_tmr | output | 1 | Timer/watchdog selected |
| tgt_write | output | 1 | Write strobe to the selected external target |
| gic_cpu | output | 2 | Processor index for the interrupt interface |
| gic_offset | output | 8 | Interrupt interface register offset |
| tmr_index | output | 3 | Timer index: processor in bits 2:1, watchdog in bit 0 |
| tmr_offset | output | 4 | Timer register offset |
| scu_enable | output | 1 | Stored control bit |
| err_flag | output | 1 | Registered one-cycle illegal-access pulse |

## Verification
The bench runs with three processors, so the explicit pages for processor 3 and an alias request from processor 3 must both be masked. A design that compares indices against the maximum of four would select a target there, and one that treats masking as an error would pulse `err_flag`. The bench also hits page boundaries (0x1FF/0x200, 0xAFF/0xB00) and bit 5 inside the timer pages. Both would catch a wrong page subtraction or a swapped timer/watchdog bit. It writes all-ones and then all-but-bit-0 to the control register, which exposes any extra writable bits, and it writes the configuration word to prove that such a write is rejected and leaves state alone. Finally it checks that the error pulse lasts exactly one cycle and that an illegal address with `req_valid` low raises nothing.

// File: rtl/priv_pkg.sv
package priv_pkg;

  localparam int OFF_W      = 12;
  localparam int PAGE_W     = 4;
  localparam int CPU_IDX_W  = 2;
  localparam int TMR_IDX_W  = CPU_IDX_W + 1;
  localparam int GIC_OFF_W  = 8;
  localparam int TMR_OFF_W  = 4;
  localparam int SCU_OFF_W  = 8;
  localparam int CFG_W      = 8;

  // page numbers (offset bits 11:8) bounding each window
  localparam logic [PAGE_W-1:0] PG_SCU       = 4'h0;
  localparam logic [PAGE_W-1:0] PG_GIC_ALIAS = 4'h1;
  localparam logic [PAGE_W-1:0] PG_GIC_FIRST = 4'h2;
  localparam logic [PAGE_W-1:0] PG_GIC_LAST  = 4'h5;
  localparam logic [PAGE_W-1:0] PG_TMR_ALIAS = 4'h6;
  localparam logic [PAGE_W-1:0] PG_TMR_FIRST = 4'h7;
  localparam logic [PAGE_W-1:0] PG_TMR_LAST  = 4'hA;

  // snoop-control register offsets
  localparam logic [SCU_OFF_W-1:0] SCU_CTRL  = 8'h00;
  localparam logic [SCU_OFF_W-1:0] SCU_CFG   = 8'h04;
  localparam logic [SCU_OFF_W-1:0] SCU_STAT  = 8'h08;
  localparam logic [SCU_OFF_W-1:0] SCU_FLUSH = 8'h0C;

  typedef enum logic [2:0] {
    RG_SCU,
    RG_GIC_ALIAS,
    RG_GIC_CPU,
    RG_TMR_ALIAS,
    RG_TMR_CPU,
    RG_BAD
  } region_e;

  // processor-present mask in the upper nibble, count minus one below
  function automatic logic [CFG_W-1:0] cfg_word(input int n);
    logic [3:0] mask;
    logic [3:0] cnt;
    mask = 4'((1 << n) - 1);
    cnt  = 4'(n - 1);
    return {mask, cnt};
  endfunction

endpackage

// File: rtl/priv_region_decode.sv
module priv_region_decode
  import priv_pkg::*;
#(
  parameter int N_CPU = 4
) (
  input  logic [PAGE_W-1:0]    page,
  input  logic [CPU_IDX_W-1:0] req_cpu,
  output region_e              region,
  output logic [CPU_IDX_W-1:0] tgt_cpu,
  output logic                 cpu_ok
);

  localparam logic [CPU_IDX_W:0] CPU_LIM = (CPU_IDX_W + 1)'(N_CPU);

  logic [PAGE_W-1:0] gic_rel;
  logic [PAGE_W-1:0] tmr_rel;
  logic              unused_rel;

  assign gic_rel    = page - PG_GIC_FIRST;
  assign tmr_rel    = page - PG_TMR_FIRST;
  assign unused_rel = ^{gic_rel[PAGE_W-1:CPU_IDX_W], tmr_rel[PAGE_W-1:CPU_IDX_W]};

  always_comb begin
    region  = RG_BAD;
    tgt_cpu = req_cpu;
    if (page == PG_SCU) begin
      region = RG_SCU;
    end else if (page == PG_GIC_ALIAS) begin
      region = RG_GIC_ALIAS;
    end else if (page >= PG_GIC_FIRST && page <= PG_GIC_LAST) begin
      region  = RG_GIC_CPU;
      tgt_cpu = gic_rel[CPU_IDX_W-1:0];
    end else if (page == PG_TMR_ALIAS) begin
      region = RG_TMR_ALIAS;
    end else if (page >= PG_TMR_FIRST && page <= PG_TMR_LAST) begin
      region  = RG_TMR_CPU;
      tgt_cpu = tmr_rel[CPU_IDX_W-1:0];
    end
  end

  assign cpu_ok = {1'b0, tgt_cpu} < CPU_LIM;

endmodule

// File: rtl/priv_scu_regs.sv
module priv_scu_regs
  import priv_pkg::*;
#(
  parameter int N_CPU  = 4,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc,
  input  logic                 wr,
  input  logic [SCU_OFF_W-1:0] off,
  input  logic                 wbit,
  output logic [DATA_W-1:0]    rdata,
  output logic                 bad_off,
  output logic                 enable
);

  localparam logic [CFG_W-1:0] CFG_VAL = cfg_word(N_CPU);

  logic ctrl_we;

  always_comb begin
    bad_off = 1'b0;
    rdata   = '0;
    ctrl_we = 1'b0;
    unique case (off)
      SCU_CTRL: begin
        rdata[0] = enable;
        ctrl_we  = acc & wr;
      end
      SCU_CFG: begin
        rdata[CFG_W-1:0] = CFG_VAL;
        bad_off          = wr;
      end
      SCU_STAT:  bad_off = wr;
      SCU_FLUSH: bad_off = 1'b0;
      default:   bad_off = 1'b1;
    endcase
    if (bad_off) rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       enable <= 1'b0;
    else if (ctrl_we) enable <= wbit;
  end

endmodule

// File: rtl/priv_rdata_mux.sv
module priv_rdata_mux #(
  parameter int NSRC   = 3,
  parameter int DATA_W = 32
) (
  input  logic [NSRC-1:0]             sel,
  input  logic [NSRC-1:0][DATA_W-1:0] src,
  output logic [DATA_W-1:0]           dout
);

  logic [NSRC-1:0][DATA_W-1:0] gated;

  for (genvar i = 0; i < NSRC; i++) begin : g_gate
    assign gated[i] = src[i] & {DATA_W{sel[i]}};
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < NSRC; i++) dout = dout | gated[i];
  end

endmodule

// File: rtl/priv_window_decoder.sv
module priv_window_decoder
  import priv_pkg::*;
#(
  parameter int N_CPU  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [1:0]           req_cpu,
  input  logic [DATA_W-1:0]    gic_rdata,
  input  logic [DATA_W-1:0]    tmr_rdata,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 sel_scu,
  output logic                 sel_gic,
  output logic                 sel_tmr,
  output logic                 tgt_write,
  output logic [1:0]           gic_cpu,
  output logic [7:0]           gic_offset,
  output logic [2:0]           tmr_index,
  output logic [3:0]           tmr_offset,
  output logic                 scu_enable,
  output logic                 err_flag
);

  localparam int NSRC = 3;

  logic [OFF_W-1:0]     off;
  logic                 unused_hi;
  region_e              region;
  logic [CPU_IDX_W-1:0] tgt_cpu;
  logic                 cpu_ok;
  logic                 scu_acc;
  logic                 scu_bad;
  logic [DATA_W-1:0]    scu_rdata;
  logic                 is_gic;
  logic                 is_tmr;
  logic                 illegal;

  assign off       = req_addr[OFF_W-1:0];
  assign unused_hi = ^{req_addr[ADDR_W-1:OFF_W], req_wdata[DATA_W-1:1]};

  priv_region_decode #(.N_CPU(N_CPU)) u_dec (
    .page    (off[OFF_W-1:OFF_W-PAGE_W]),
    .req_cpu (req_cpu),
    .region  (region),
    .tgt_cpu (tgt_cpu),
    .cpu_ok  (cpu_ok)
  );

  assign scu_acc = req_valid && (region == RG_SCU);

  priv_scu_regs #(.N_CPU(N_CPU), .DATA_W(DATA_W)) u_scu (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (scu_acc),
    .wr      (req_write),
    .off     (off[SCU_OFF_W-1:0]),
    .wbit    (req_wdata[0]),
    .rdata   (scu_rdata),
    .bad_off (scu_bad),
    .enable  (scu_enable)
  );

  assign is_gic = (region == RG_GIC_ALIAS) || (region == RG_GIC_CPU);
  assign is_tmr = (region == RG_TMR_ALIAS) || (region == RG_TMR_CPU);

  assign sel_scu   = scu_acc && !scu_bad;
  assign sel_gic   = req_valid && is_gic && cpu_ok;
  assign sel_tmr   = req_valid && is_tmr && cpu_ok;
  assign tgt_write = req_write && (sel_gic || sel_tmr);
  assign illegal   = req_valid && ((region == RG_BAD) || (region == RG_SCU && scu_bad));

  assign gic_cpu    = tgt_cpu;
  assign gic_offset = off[GIC_OFF_W-1:0];
  assign tmr_index  = {tgt_cpu, off[5]};
  assign tmr_offset = off[TMR_OFF_W-1:0];

  priv_rdata_mux #(.NSRC(NSRC), .DATA_W(DATA_W)) u_mux (
    .sel  ({sel_tmr, sel_gic, sel_scu}),
    .src  ({tmr_rdata, gic_rdata, scu_rdata}),
    .dout (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_flag <= 1'b0;
    else        err_flag <= illegal;
  end

endmodule

// File: rtl/priv_window_decoder_chk.sv
module priv_window_decoder_chk #(
  parameter int N_CPU  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_cpu,
  input logic [DATA_W-1:0] rd_data,
  input logic              sel_scu,
  input logic              sel_gic,
  input logic              sel_tmr,
  input logic              tgt_write,
  input logic [2:0]        tmr_index,
  input logic              scu_enable,
  input logic              err_flag
);

  logic [11:0] a;
  logic        hi_bad;
  logic        expl_gic_masked;
  logic        ctrl_wr;

  assign a               = req_addr[11:0];
  assign hi_bad          = req_valid && (a >= 12'hB00);
  assign expl_gic_masked = req_valid && (a >= 12'h200) && (a < 12'h600)
                           && (int'((a - 12'h200) >> 8) >= N_CPU);
  assign ctrl_wr         = req_valid && req_write && (a == 12'h000);

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_scu, sel_gic, sel_tmr})); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!sel_scu && !sel_gic && !sel_tmr && rd_data == '0)); // R1

  AST_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_write |-> (req_write && (sel_gic || sel_tmr))); // R10

  AST_HIGH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    hi_bad |=> err_flag); // R9

  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hi_bad |-> (rd_data == '0 && !sel_scu && !sel_gic && !sel_tmr)); // R9

  AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    expl_gic_masked |=> !err_flag); // R8

  AST_MASK_NOSEL: assert property (@(posedge clk) disable iff (!rst_n)
    expl_gic_masked |-> !sel_gic); // R8

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(scu_enable)); // R2

  AST_WDOG_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    sel_tmr |-> (tmr_index[0] == a[5])); // R6

  AST_ALIAS_TMR_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_tmr && a[11:8] == 4'h6) |-> (tmr_index[2:1] == req_cpu)); // R6

endmodule

bind priv_window_decoder priv_window_decoder_chk #(
  .N_CPU(N_CPU), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (.*);

// File: tb/priv_window_decoder_tb_top.sv
module priv_window_decoder_tb_top;

  localparam int N_CPU  = 3;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam logic [31:0] GIC_RD = 32'h6100_00AA;
  localparam logic [31:0] TMR_RD = 32'h7700_0055;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [1:0]        req_cpu = '0;
  logic [DATA_W-1:0] rd_data;
  logic              sel_scu, sel_gic, sel_tmr, tgt_write;
  logic [1:0]        gic_cpu;
  logic [7:0]        gic_offset;
  logic [2:0]        tmr_index;
  logic [3:0]        tmr_offset;
  logic              scu_enable, err_flag;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  always #2 clk = ~clk;

  priv_window_decoder #(.N_CPU(N_CPU), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cpu(req_cpu),
    .gic_rdata(GIC_RD), .tmr_rdata(TMR_RD), .rd_data(rd_data),
    .sel_scu(sel_scu), .sel_gic(sel_gic), .sel_tmr(sel_tmr), .tgt_write(tgt_write),
    .gic_cpu(gic_cpu), .gic_offset(gic_offset), .tmr_index(tmr_index),
    .tmr_offset(tmr_offset), .scu_enable(scu_enable), .err_flag(err_flag)
  );

  // sel is {scu, gic, tmr}; idx is gic_cpu or tmr_index; req is the requirement number
  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic [1:0]  cpu;
    logic [2:0]  sel;
    logic [2:0]  idx;
    logic [7:0]  off;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0104, 1'b0, 2'd1, 3'b010, 3'd1, 8'h04, 1'b0, 4'd4},  // R4 alias
    '{32'h0000_01FC, 1'b1, 2'd2, 3'b010, 3'd2, 8'hFC, 1'b0, 4'd4},  // R4 top of page
    '{32'h0000_0210, 1'b0, 2'd0, 3'b010, 3'd0, 8'h10, 1'b0, 4'd5},  // R5 cpu0
    '{32'h0000_0420, 1'b1, 2'd0, 3'b010, 3'd2, 8'h20, 1'b0, 4'd5},  // R5 cpu2
    '{32'h0000_0500, 1'b0, 2'd1, 3'b000, 3'd0, 8'h00, 1'b0, 4'd8},  // R8 cpu3 gic
    '{32'h0000_0608, 1'b0, 2'd1, 3'b001, 3'd2, 8'h08, 1'b0, 4'd6},  // R6 timer
    '{32'h0000_062C, 1'b1, 2'd2, 3'b001, 3'd5, 8'h0C, 1'b0, 4'd6},  // R6 watchdog
    '{32'h0000_0724, 1'b0, 2'd2, 3'b001, 3'd1, 8'h04, 1'b0, 4'd7},  // R7 cpu0 wdog
    '{32'h0000_0900, 1'b1, 2'd0, 3'b001, 3'd4, 8'h00, 1'b0, 4'd7},  // R7 cpu2
    '{32'h0000_0AFF, 1'b0, 2'd0, 3'b000, 3'd0, 8'h00, 1'b0, 4'd8},  // R8 cpu3 timer
    '{32'h0000_0B00, 1'b0, 2'd0, 3'b000, 3'd0, 8'h00, 1'b1, 4'd9},  // R9 first bad
    '{32'h0000_0FFC, 1'b1, 2'd1, 3'b000, 3'd0, 8'h00, 1'b1, 4'd9},  // R9 last bad
    '{32'hFFFF_F108, 1'b0, 2'd0, 3'b010, 3'd0, 8'h08, 1'b0, 4'd11}, // R11
    '{32'h1234_5730, 1'b0, 2'd1, 3'b001, 3'd1, 8'h00, 1'b0, 4'd11}, // R11
    '{32'h0000_0100, 1'b0, 2'd3, 3'b000, 3'd0, 8'h00, 1'b0, 4'd8},  // R8 alias cpu3
    '{32'h0000_0010, 1'b0, 2'd0, 3'b000, 3'd0, 8'h00, 1'b1, 4'd9}   // R9 bad SCU offset
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic w, input logic [1:0] c, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = a;
    req_cpu   = c;
    req_wdata = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
    #1;
  endtask

  task automatic edge_after();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(scu_enable == 1'b0, "R1 enable", 32'(scu_enable), 32'd0);
    chk(err_flag == 1'b0, "R1 err", 32'(err_flag), 32'd0);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk({sel_scu, sel_gic, sel_tmr, tgt_write} == 4'b0, "R1 idle sel",
        32'({sel_scu, sel_gic, sel_tmr, tgt_write}), 32'd0);
    chk(rd_data == '0, "R1 idle rd", rd_data, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [31:0] exp_rd;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v.req, i);
      drive(v.addr, v.wr, v.cpu, 32'hDEAD_BEEF);
      exp_rd = v.sel[1] ? GIC_RD : (v.sel[0] ? TMR_RD : 32'd0);
      chk({sel_scu, sel_gic, sel_tmr} == v.sel, {tag, " sel"},
          32'({sel_scu, sel_gic, sel_tmr}), 32'(v.sel));
      chk(rd_data == exp_rd, {tag, " rd"}, rd_data, exp_rd);
      chk(tgt_write == (v.wr && (v.sel[1] || v.sel[0])), {tag, " wr"},
          32'(tgt_write), 32'(v.wr && (v.sel[1] || v.sel[0])));
      if (v.sel[1]) begin
        chk(gic_cpu == v.idx[1:0], {tag, " cpu"}, 32'(gic_cpu), 32'(v.idx[1:0]));
        chk(gic_offset == v.off, {tag, " off"}, 32'(gic_offset), 32'(v.off));
      end
      if (v.sel[0]) begin
        chk(tmr_index == v.idx, {tag, " tidx"}, 32'(tmr_index), 32'(v.idx));
        chk(tmr_offset == v.off[3:0], {tag, " toff"}, 32'(tmr_offset), 32'(v.off[3:0]));
      end
      edge_after();
      chk(err_flag == v.err, {tag, " err"}, 32'(err_flag), 32'(v.err));
    end

    // R9 error pulse lasts one cycle
    drive(32'h0000_0C00, 1'b0, 2'd0, 32'd0);
    idle();
    chk(err_flag == 1'b1, "R9 pulse high", 32'(err_flag), 32'd1);
    edge_after();
    chk(err_flag == 1'b0, "R9 pulse low", 32'(err_flag), 32'd0);

    // R10 illegal address with valid low raises nothing
    @(negedge clk);
    req_addr = 32'h0000_0D00;
    #1;
    chk(rd_data == '0, "R10 idle rd", rd_data, 32'd0);
    edge_after();
    chk(err_flag == 1'b0, "R10 idle err", 32'(err_flag), 32'd0);

    // R3 configuration word
    drive(32'h0000_0004, 1'b0, 2'd0, 32'd0);
    chk(sel_scu == 1'b1, "R3 cfg sel", 32'(sel_scu), 32'd1);
    chk(rd_data == 32'h72, "R3 cfg", rd_data, 32'h72);

    // R2 control write, only bit 0 kept
    drive(32'h0000_0000, 1'b1, 2'd0, 32'hFFFF_FFFF);
    edge_after();
    chk(scu_enable == 1'b1, "R2 set", 32'(scu_enable), 32'd1);
    drive(32'h0000_0000, 1'b0, 2'd0, 32'd0);
    chk(rd_data == 32'd1, "R2 readback", rd_data, 32'd1);

    // R3 flush write accepted, status/flush read zero
    drive(32'h0000_000C, 1'b1, 2'd1, 32'hFFFF_FFFF);
    edge_after();
    chk(err_flag == 1'b0, "R3 flush err", 32'(err_flag), 32'd0);
    chk(scu_enable == 1'b1, "R3 flush no effect", 32'(scu_enable), 32'd1);
    drive(32'h0000_000C, 1'b0, 2'd0, 32'd0);
    chk(rd_data == 32'd0, "R3 flush read", rd_data, 32'd0);
    drive(32'h0000_0008, 1'b0, 2'd0, 32'd0);
    chk(rd_data == 32'd0, "R3 status read", rd_data, 32'd0);

    // R9 write to configuration word is illegal and keeps state
    drive(32'h0000_0004, 1'b1, 2'd0, 32'h0);
    chk(sel_scu == 1'b0, "R9 cfg write sel", 32'(sel_scu), 32'd0);
    edge_after();
    chk(err_flag == 1'b1, "R9 cfg write err", 32'(err_flag), 32'd1);
    chk(scu_enable == 1'b1, "R9 cfg write state", 32'(scu_enable), 32'd1);

    // R2 clear with bit 0 low and all other bits high
    drive(32'h0000_0000, 1'b1, 2'd0, 32'hFFFF_FFFE);
    edge_after();
    chk(scu_enable == 1'b0, "R2 clear", 32'(scu_enable), 32'd0);
    drive(32'h0000_0000, 1'b0, 2'd0, 32'd0);
    chk(rd_data == 32'd0, "R2 readback zero", rd_data, 32'd0);
    idle();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule